// File: doc/BRIEF.md
# Access-Dependent Stretched Processor Clock Generator

This block derives the processor input clock from a 16 MHz master clock. The length of every processor cycle is chosen afresh when the clock falls. The choice depends on what that cycle accesses and on the current display mode. Read-only memory cycles run at the full 2 MHz rate. Peripheral cycles, and memory cycles in the low-bandwidth display modes, fall back to 1 MHz. Their high phase is lengthened so that the cycle finishes on the edge of a hidden 1 MHz phase, which lets slow peripherals that are clocked from that phase keep step with the processor.

In the high-bandwidth display modes the video fetch owns the RAM while the visible part of a line is drawn. A RAM cycle that begins inside that window keeps the processor clock high until the window closes. The block has its own line and frame counters to track the window and reports it on a flag. It also produces a baud reference at the master rate divided by thirteen.

The access class encoding is 2'b00 read-only memory, 2'b01 peripheral, 2'b10 RAM, and 2'b11, which is treated as a peripheral. All timings below are counted in master cycles. A master cycle is numbered from 0, which is the first cycle after reset is released.

Top module: `vclk_stretch_gen`

## Requirements
- R1: While reset is asserted the processor clock is low. The first processor cycle after reset is a read-only memory cycle: low for master cycles 0 to 3, high for 4 to 7, and falling at master cycle 8.
- R2: Every low phase of the processor clock lasts exactly 4 master cycles.
- R3: A cycle whose access class is 2'b00 has a 4-cycle high phase in every mode, whether or not the display window is open.
- R4: A cycle with class 2'b01 or 2'b11 has a high phase of 12 or 20 master cycles. The following fall lands on a master cycle whose number is a multiple of 16, which is the rising edge of the hidden 1 MHz phase. The high phase is the shortest one of at least 12 cycles that meets this.
- R5: A RAM cycle (class 2'b10) in modes 4 to 7 is timed exactly as in R4.
- R6: A RAM cycle in modes 0 to 3 whose high phase starts inside the display window stays high until the window closes. It falls on the first multiple-of-16 master cycle that is at least 16 cycles after its low phase began and lies outside the window. The worst case, low phase starting at the first position of a visible line, gives a 636-cycle high phase.
- R7: A RAM cycle in modes 0 to 3 whose high phase starts outside the display window, in the blank part of a line or in a blank line, is timed as in R4.
- R8: The access class and mode are captured at the master edge on which the processor clock falls. Changes to them during the low or high phase of that cycle do not alter its length.
- R9: The display flag is high when the position within the line (master cycle modulo 1024) is below 640 and the line number within the frame (line count modulo the frame length, 312 by default) is below the visible line count (256 by default).
- R10: The baud reference has a period of 13 master cycles. It is high for 7 and low for 6, and it is high in master cycles 0 to 6 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_class | input | 2 | Access class of the next processor cycle |
| disp_mode | input | 3 | Display mode number, 0 to 7 |
| cpu_clk | output | 1 | Stretched processor input clock |
| disp_active | output | 1 | High while the visible display window is open |
| baud_clk | output | 1 | Baud reference at master clock divided by 13 |

## Verification
The class and mode take effect at the master edge that lowers the processor clock. The clock then rises 4 master cycles later and falls again after the high length that those inputs select. The bench therefore drives each class during the preceding high phase and pushes it into a queue. It then scrambles the inputs right after the fall. Its monitor, which runs half a master cycle away from the active edge, counts master cycles since reset and pops one expected item on each fall. From the fall time it computes the due edge using its own model of the hidden phase and the display window. The display flag and the baud reference are registered-counter outputs that are valid in the same master cycle as the count. They are compared against the same count every cycle, with no added delay.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

   typedef enum logic [1:0] {
      ACC_ROM = 2'b00,
      ACC_IO  = 2'b01,
      ACC_RAM = 2'b10,
      ACC_RSV = 2'b11
   } acc_e;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   typedef enum logic [1:0] {
      HK_FAST = 2'b00,
      HK_SLOW = 2'b01,
      HK_HOLD = 2'b10
   } hkind_e;

endpackage

// File: rtl/vclk_modcnt.sv
// Free-running modulo counter with a count enable.
module vclk_modcnt #(
   parameter int MOD = 16,
   localparam int W = (MOD > 1) ? $clog2(MOD) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   output logic [W-1:0] count
);

   if (MOD < 2) begin : g_bad_mod
      $error("vclk_modcnt: MOD must be at least 2");
   end

   logic wrap;
   assign wrap = (count == W'(MOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (en)
         count <= wrap ? '0 : count + 1'b1;
   end

endmodule

// File: rtl/vclk_raster.sv
// Line position and line number counters, with window flags for now and next cycle.
module vclk_raster #(
   parameter int H_TOTAL   = 1024,
   parameter int H_VISIBLE = 640,
   parameter int V_TOTAL   = 312,
   parameter int V_VISIBLE = 256,
   localparam int HW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1,
   localparam int VW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic vis_now,
   output logic vis_next
);

   logic [HW-1:0] h_cnt, h_nx;
   logic [VW-1:0] v_cnt, v_nx;
   logic          h_last, v_last;

   vclk_modcnt #(.MOD(H_TOTAL)) u_hcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .count (h_cnt)
   );

   vclk_modcnt #(.MOD(V_TOTAL)) u_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (h_last),
      .count (v_cnt)
   );

   assign h_last = (h_cnt == HW'(H_TOTAL - 1));
   assign v_last = (v_cnt == VW'(V_TOTAL - 1));

   always_comb begin
      h_nx = h_last ? '0 : h_cnt + 1'b1;
      if (h_last)
         v_nx = v_last ? '0 : v_cnt + 1'b1;
      else
         v_nx = v_cnt;
   end

   assign vis_now  = ({1'b0, h_cnt} < (HW+1)'(H_VISIBLE)) &&
                     ({1'b0, v_cnt} < (VW+1)'(V_VISIBLE));
   assign vis_next = ({1'b0, h_nx}  < (HW+1)'(H_VISIBLE)) &&
                     ({1'b0, v_nx}  < (VW+1)'(V_VISIBLE));

endmodule

// File: rtl/vclk_phase_fsm.sv
// Low/high phase sequencer for the processor clock.
module vclk_phase_fsm
   import vclk_pkg::*;
#(
   parameter int LOW_LEN       = 4,
   parameter int FAST_HIGH     = 4,
   parameter int SLOW_PERIOD   = 16,
   parameter int MODE_W        = 3,
   parameter int STALL_MODES   = 4,
   localparam int PW           = (SLOW_PERIOD > 1) ? $clog2(SLOW_PERIOD) : 1,
   localparam int SLOW_MIN     = SLOW_PERIOD - LOW_LEN,
   localparam int CNT_MAX      = (SLOW_MIN > LOW_LEN) ?
                                 ((SLOW_MIN > FAST_HIGH) ? SLOW_MIN : FAST_HIGH) :
                                 ((LOW_LEN > FAST_HIGH) ? LOW_LEN : FAST_HIGH),
   localparam int CW           = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        acc_class,
   input  logic [MODE_W-1:0] disp_mode,
   input  logic [PW-1:0]     hid_phase,
   input  logic              vis_next,
   output logic              cpu_clk
);

   phase_e            phase_q;
   hkind_e            kind_q, kind_d;
   logic [CW-1:0]     cnt_q;
   acc_e              acc_q;
   logic [MODE_W-1:0] mode_q;
   logic              stall_mode;
   logic              hid_edge;
   logic              low_done, high_done, slow_ok;

   // Mode range that gives the video fetch priority over RAM.
   if (STALL_MODES > 0) begin : g_stall
      assign stall_mode = ({1'b0, mode_q} < (MODE_W+1)'(STALL_MODES));
   end else begin : g_nostall
      assign stall_mode = 1'b0;
   end

   // Last master cycle before the hidden 1 MHz rising edge.
   assign hid_edge = (hid_phase == PW'(SLOW_PERIOD - 1));

   always_comb begin
      if (acc_q == ACC_ROM)
         kind_d = HK_FAST;
      else if (acc_q == ACC_RAM && stall_mode && vis_next)
         kind_d = HK_HOLD;
      else
         kind_d = HK_SLOW;
   end

   assign low_done = (phase_q == PH_LOW) && (cnt_q == CW'(LOW_LEN - 1));
   assign slow_ok  = hid_edge && (cnt_q >= CW'(SLOW_MIN - 1));

   always_comb begin
      high_done = 1'b0;
      if (phase_q == PH_HIGH) begin
         unique case (kind_q)
            HK_FAST: high_done = (cnt_q == CW'(FAST_HIGH - 1));
            HK_SLOW: high_done = slow_ok;
            HK_HOLD: high_done = slow_ok && !vis_next;
            default: high_done = slow_ok;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_LOW;
         kind_q  <= HK_FAST;
         cnt_q   <= '0;
         acc_q   <= ACC_ROM;
         mode_q  <= '0;
      end else if (low_done) begin
         phase_q <= PH_HIGH;
         kind_q  <= kind_d;
         cnt_q   <= '0;
      end else if (high_done) begin
         phase_q <= PH_LOW;
         cnt_q   <= '0;
         acc_q   <= acc_e'(acc_class);
         mode_q  <= disp_mode;
      end else if (cnt_q != CW'(CNT_MAX)) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign cpu_clk = (phase_q == PH_HIGH);

endmodule

// File: rtl/vclk_stretch_gen.sv
// Top: stretched processor clock, display window flag and baud reference.
module vclk_stretch_gen #(
   parameter int H_TOTAL     = 1024,
   parameter int H_VISIBLE   = 640,
   parameter int V_TOTAL     = 312,
   parameter int V_VISIBLE   = 256,
   parameter int LOW_LEN     = 4,
   parameter int FAST_HIGH   = 4,
   parameter int SLOW_PERIOD = 16,
   parameter int MODE_W      = 3,
   parameter int STALL_MODES = 4,
   parameter int BAUD_DIV    = 13,
   parameter bit BAUD_SQUARE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        acc_class,
   input  logic [MODE_W-1:0] disp_mode,
   output logic              cpu_clk,
   output logic              disp_active,
   output logic              baud_clk
);

   localparam int PW      = (SLOW_PERIOD > 1) ? $clog2(SLOW_PERIOD) : 1;
   localparam int BW      = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
   localparam int BAUD_HI = (BAUD_DIV + 1) / 2;

   if (SLOW_PERIOD % (LOW_LEN + FAST_HIGH) != 0) begin : g_bad_ratio
      $error("fast cycle must divide the hidden slow period");
   end
   if (SLOW_PERIOD - LOW_LEN <= FAST_HIGH) begin : g_bad_slow
      $error("slow high phase must exceed the fast one");
   end
   if (H_TOTAL % SLOW_PERIOD != 0 || H_VISIBLE % SLOW_PERIOD != 0) begin : g_bad_line
      $error("line and window lengths must be whole slow periods");
   end
   if (H_VISIBLE > H_TOTAL || V_VISIBLE > V_TOTAL) begin : g_bad_win
      $error("visible region larger than the frame");
   end
   if (STALL_MODES > (1 << MODE_W)) begin : g_bad_modes
      $error("STALL_MODES exceeds the mode range");
   end

   logic [PW-1:0] hid_phase;
   logic [BW-1:0] baud_cnt;
   logic          vis_next;

   vclk_modcnt #(.MOD(SLOW_PERIOD)) u_hidden (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .count (hid_phase)
   );

   vclk_raster #(
      .H_TOTAL   (H_TOTAL),
      .H_VISIBLE (H_VISIBLE),
      .V_TOTAL   (V_TOTAL),
      .V_VISIBLE (V_VISIBLE)
   ) u_raster (
      .clk      (clk),
      .rst_n    (rst_n),
      .vis_now  (disp_active),
      .vis_next (vis_next)
   );

   vclk_phase_fsm #(
      .LOW_LEN     (LOW_LEN),
      .FAST_HIGH   (FAST_HIGH),
      .SLOW_PERIOD (SLOW_PERIOD),
      .MODE_W      (MODE_W),
      .STALL_MODES (STALL_MODES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_class (acc_class),
      .disp_mode (disp_mode),
      .hid_phase (hid_phase),
      .vis_next  (vis_next),
      .cpu_clk   (cpu_clk)
   );

   vclk_modcnt #(.MOD(BAUD_DIV)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .count (baud_cnt)
   );

   if (BAUD_SQUARE) begin : g_baud_sq
      assign baud_clk = ({1'b0, baud_cnt} < (BW+1)'(BAUD_HI));
   end else begin : g_baud_strobe
      assign baud_clk = (baud_cnt == BW'(BAUD_DIV - 1));
   end

endmodule

// File: rtl/vclk_stretch_gen_chk.sv
// Property checker, bound to every vclk_stretch_gen instance.
module vclk_stretch_gen_chk #(
   parameter int LOW_LEN     = 4,
   parameter int FAST_HIGH   = 4,
   parameter int SLOW_PERIOD = 16,
   parameter int MODE_W      = 3,
   parameter int STALL_MODES = 4,
   parameter int BAUD_DIV    = 13,
   parameter bit BAUD_SQUARE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        acc_class,
   input logic [MODE_W-1:0] disp_mode,
   input logic              cpu_clk,
   input logic              disp_active,
   input logic              baud_clk
);

   localparam int SLOW_MIN = SLOW_PERIOD - LOW_LEN;
   localparam int SLOW_ALT = SLOW_MIN + LOW_LEN + FAST_HIGH;
   localparam int BAUD_HI  = (BAUD_DIV + 1) / 2;

   logic [15:0]       lo_run, hi_run, b_hi, b_lo;
   logic [1:0]        acc_l, cyc_acc;
   logic [MODE_W-1:0] mode_l, cyc_mode;
   logic              cyc_win, cpu_q;
   logic              cyc_low_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run   <= '0;
         hi_run   <= '0;
         b_hi     <= '0;
         b_lo     <= '0;
         acc_l    <= 2'b00;
         mode_l   <= '0;
         cyc_acc  <= 2'b00;
         cyc_mode <= '0;
         cyc_win  <= 1'b0;
         cpu_q    <= 1'b0;
      end else begin
         cpu_q  <= cpu_clk;
         lo_run <= cpu_clk ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
         hi_run <= !cpu_clk ? '0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1);
         b_hi   <= !baud_clk ? '0 : ((b_hi == 16'hFFFF) ? b_hi : b_hi + 1'b1);
         b_lo   <= baud_clk ? '0 : ((b_lo == 16'hFFFF) ? b_lo : b_lo + 1'b1);
         if (cpu_clk) begin
            acc_l  <= acc_class;
            mode_l <= disp_mode;
         end
         if (cpu_clk && !cpu_q) begin
            cyc_acc  <= acc_l;
            cyc_mode <= mode_l;
            cyc_win  <= disp_active;
         end
      end
   end

   assign cyc_low_mode = ({1'b0, cyc_mode} < (MODE_W+1)'(STALL_MODES));

   // R2: fixed low phase
   p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk) |-> (lo_run == 16'(LOW_LEN)));

   // R3: read-only memory cycles are fast
   p_rom_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_clk) && cyc_acc == 2'b00) |-> (hi_run == 16'(FAST_HIGH)));

   // R4: peripheral cycles are slow and aligned
   p_io_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_clk) && cyc_acc[0]) |->
         (hi_run == 16'(SLOW_MIN) || hi_run == 16'(SLOW_ALT)));

   // R5: RAM in low-bandwidth modes is slow
   p_ram_lomode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_clk) && cyc_acc == 2'b10 && !cyc_low_mode) |->
         (hi_run == 16'(SLOW_MIN) || hi_run == 16'(SLOW_ALT)));

   // R6: RAM held while the window stays open
   p_ram_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk && cpu_q && cyc_acc == 2'b10 && cyc_low_mode && cyc_win && disp_active)
         |=> (cpu_clk || !disp_active));

   // R7: RAM outside the window is slow
   p_ram_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_clk) && cyc_acc == 2'b10 && cyc_low_mode && !cyc_win) |->
         (hi_run == 16'(SLOW_MIN) || hi_run == 16'(SLOW_ALT)));

   if (BAUD_SQUARE) begin : g_baud_props
      // R10: baud duty
      p_baud_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(baud_clk) |-> (b_hi == 16'(BAUD_HI)));
      p_baud_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(baud_clk) |-> (b_lo == 16'(BAUD_DIV - BAUD_HI)));
   end

endmodule

bind vclk_stretch_gen vclk_stretch_gen_chk #(
   .LOW_LEN     (LOW_LEN),
   .FAST_HIGH   (FAST_HIGH),
   .SLOW_PERIOD (SLOW_PERIOD),
   .MODE_W      (MODE_W),
   .STALL_MODES (STALL_MODES),
   .BAUD_DIV    (BAUD_DIV),
   .BAUD_SQUARE (BAUD_SQUARE)
) u_chk (.*);

// File: tb/vclk_stretch_gen_test.sv
`timescale 1ns/1ps
module vclk_stretch_gen_test;

   localparam int CLK_PERIOD = 62;
   localparam int HT   = 1024;
   localparam int HV   = 640;
   localparam int VT   = 12;
   localparam int VV   = 8;
   localparam int LOWL = 4;
   localparam int FH   = 4;
   localparam int SP   = 16;
   localparam int BD   = 13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] acc_class = 2'b00;
   logic [2:0] disp_mode = 3'd0;
   logic       cpu_clk, disp_active, baud_clk;

   vclk_stretch_gen #(
      .H_TOTAL(HT), .H_VISIBLE(HV), .V_TOTAL(VT), .V_VISIBLE(VV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .acc_class(acc_class), .disp_mode(disp_mode),
      .cpu_clk(cpu_clk), .disp_active(disp_active), .baud_clk(baud_clk)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct { int acc; int mode; } item_t;
   item_t q[$];

   int n_cmp = 0, n_bad = 0, tcnt = 0;
   int max_hold = 0, blank_r7 = 0;
   bit dprev = 1'b0;

   always @(posedge clk) if (rst_n) tcnt <= tcnt + 1;

   function automatic bit vis(int t);
      return ((t % HT) < HV) && (((t / HT) % VT) < VV);
   endfunction

   function automatic int exp_high(int t0, int acc, int mode, output string req);
      int hs, e;
      hs = t0 + LOWL;
      if (acc == 0) begin req = "R3"; return FH; end
      e = ((t0 + SP + SP - 1) / SP) * SP;
      if (acc != 2) req = "R4";
      else if (mode >= 4) req = "R5";
      else if (vis(hs)) begin
         req = "R6";
         while (vis(e)) e += SP;
      end else req = "R7";
      return e - hs;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, expv, tcnt);
      end
   endtask

   task automatic wait_rise();
      forever begin
         @(negedge clk);
         if (cpu_clk && !dprev) begin dprev = cpu_clk; break; end
         dprev = cpu_clk;
      end
   endtask

   task automatic wait_fall();
      forever begin
         @(negedge clk);
         if (!cpu_clk && dprev) begin dprev = cpu_clk; break; end
         dprev = cpu_clk;
      end
   endtask

   // Driver: set class during the high phase, scramble it after the fall (R8).
   task automatic run_cycle(int acc, int mode);
      item_t it;
      wait_rise();
      acc_class = 2'(acc);
      disp_mode = 3'(mode);
      it.acc = acc; it.mode = mode;
      q.push_back(it);
      wait_fall();
      acc_class = (acc == 2) ? 2'b00 : 2'b10;
      disp_mode = (mode < 4) ? 3'(7 - mode) : 3'(mode - 4);
   endtask

   // Monitor: measure each phase and compare with the popped expectation.
   initial begin : monitor
      int t, lo_start, hi_start, cur_exp, len, hs_line;
      string cur_req, nreq;
      bit prev;
      item_t it;
      prev = 1'b0; lo_start = 0; hi_start = 0;
      cur_exp = exp_high(0, 0, 0, cur_req);
      cur_req = "R1";
      wait (rst_n);
      forever begin
         @(negedge clk);
         t = tcnt;
         if (t < BD * 24)
            check(baud_clk == ((t % BD) < 7), "R10", int'(baud_clk), int'((t % BD) < 7));
         if (cpu_clk && !prev) begin
            check(t - lo_start == LOWL, (t == LOWL) ? "R1" : "R2", t - lo_start, LOWL);
            hi_start = t;
         end else if (!cpu_clk && prev) begin
            len = t - hi_start;
            if (cur_exp >= 0) begin
               check(len == cur_exp, {cur_req, " (inputs scrambled after fall, R8)"},
                     len, cur_exp);
               if (cur_req == "R6" && len > max_hold) max_hold = len;
            end
            check(disp_active == vis(t), "R9", int'(disp_active), int'(vis(t)));
            lo_start = t;
            if (q.size() > 0) begin
               it = q.pop_front();
               cur_exp = exp_high(t, it.acc, it.mode, nreq);
               cur_req = nreq;
               hs_line = ((t + LOWL) / HT) % VT;
               if (nreq == "R7" && hs_line >= VV) blank_r7++;
            end else begin
               cur_exp = -1;
            end
         end
         prev = cpu_clk;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(cpu_clk == 1'b0, "R1", int'(cpu_clk), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R3 R4 R5 R6 R7: every class and mode
      for (int m = 0; m < 8; m++)
         for (int a = 0; a < 4; a++)
            for (int k = 0; k < 3; k++)
               run_cycle(a, m);
      // R6 worst case: a stall, 48 fast cycles, then RAM at a line start
      for (int r = 0; r < 14; r++) begin
         run_cycle(2, 0);
         for (int k = 0; k < 48; k++) run_cycle(0, 1);
      end
      // R7: long RAM run in mode 3, crossing blank lines
      for (int k = 0; k < 400; k++) run_cycle(2, 3);
      wait_rise();
      wait_fall();
      repeat (2) @(negedge clk);
      check(max_hold == HV - LOWL, "R6 worst-case stretch", max_hold, HV - LOWL);
      check(blank_r7 > 0, "R7 blank-line RAM cycles seen", blank_r7, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule